// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Generator

This block watches the chip-select line of a serial slave port and drives a system reset whenever that line has been quiet for longer than a chosen interval. Quiet means the line stays high or stays low. Only a high-to-low transition of chip select counts as activity and restarts the count. A 2-bit select input picks one of three preset intervals, or turns the watchdog off. When the count expires, the reset output is active for a fixed number of cycles. After that pulse the count starts again from zero.

The reset output is modelled as an open-drain pad. An enable says when the pad pulls toward its active level, and a separate output gives that level. The active level is fixed by a build parameter. When the power-on reset is released, the output stays active for a fixed power-up period before the watchdog starts counting. All intervals and pulse widths are parameters given in clock cycles. Chip select passes through a two-flop synchroniser before edge detection, so it may come from another clock domain.

Top module: `wdr_bus_watchdog`

## Requirements
- R1: While `por_n` is low, `rst_oe` is 1. Counting the cycle in which `por_n` is released, `rst_oe` stays 1 for exactly `PUR_CYCLES` cycles and then drops to 0.
- R2: With chip select steady, the output is inactive for exactly the selected interval after each reset pulse ends, and then the next pulse starts. The codes on `wd_sel` are: 0 selects `TMO_SHORT`, 1 selects `TMO_MID`, 2 selects `TMO_LONG`. A code written while a pulse is active applies to the gap that follows it.
- R3: A pulse caused by a timeout keeps `rst_oe` at 1 for exactly `RST_CYCLES` cycles.
- R4: `wd_sel` = 3 disables the watchdog: no timeout pulse is produced, however long chip select stays quiet.
- R5: A falling edge on `cs_n` restarts the count. If `cs_n` falls and then stays low, `rst_oe` rises on the (interval + 3)-th clock edge after the change: two synchroniser stages, one edge-detect stage, then the interval.
- R6: A rising edge on `cs_n` does not restart the count. The gap after a pulse stays equal to the interval when `cs_n` rises during it.
- R7: Falling edges that come more often than the selected interval keep `rst_oe` at 0.
- R8: `rst_lvl` is 0 when `ACT_LOW` is 1 and 1 when `ACT_LOW` is 0. `rst_oe` is 1 only while the reset is active.
- R9: If the interval is shortened below the count already reached, the timeout fires on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cs_n | input | 1 | Chip-select line being watched, asynchronous to clk |
| wd_sel | input | 2 | Interval select: 0 short, 1 mid, 2 long, 3 off |
| rst_oe | output | 1 | Open-drain enable: 1 drives the pad to `rst_lvl` |
| rst_lvl | output | 1 | Active level of the reset pad |

## Verification
On every cycle, the checker confirms that each reset pulse lasts either the power-up width or the timeout width. It also confirms that a trip from the timer always starts a pulse, that no trip happens during a pulse, that nothing trips while the select code is 3, and that a quiet stretch never goes past the longest interval. It cannot tell which interval should apply, or whether the count restarted on the right edge. The directed scenarios cover those points. They measure the exact gap for each select code, the three-cycle latency after a falling edge, the fact that a rising edge does not restart the count, kicks that arrive in time, and a trip caused by shortening the interval.

// File: rtl/wdr_pkg.sv
`timescale 1ns/1ps
package wdr_pkg;

    // Interval select codes; the last code turns the timer off.
    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'd0,
        WD_SEL_MID   = 2'd1,
        WD_SEL_LONG  = 2'd2,
        WD_SEL_OFF   = 2'd3
    } wd_sel_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdr_cs_sync.sv
`timescale 1ns/1ps
// Brings chip select into the clk domain and flags its falling edges.
module wdr_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] sh;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1};
        else        st_q <= st_d;
    end

    // Edge stage is the oldest bit: high before, low now.
    assign fall_o = st_q.sh[LEN-1] & ~st_q.sh[LEN-2];

endmodule

// File: rtl/wdr_timer.sv
`timescale 1ns/1ps
// Counts quiet cycles and raises a one-cycle trip at the selected limit.
module wdr_timer
    import wdr_pkg::*;
#(
    parameter int TMO_SHORT = 10,
    parameter int TMO_MID   = 20,
    parameter int TMO_LONG  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       restart,
    input  logic       hold,
    output logic       trip_o
);
    localparam int TMAX = max3(TMO_SHORT, TMO_MID, TMO_LONG);
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LAST_S = CW'(TMO_SHORT - 1);
    localparam logic [CW-1:0] LAST_M = CW'(TMO_MID - 1);
    localparam logic [CW-1:0] LAST_L = CW'(TMO_LONG - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s          st_d, st_q;
    logic [CW-1:0] last_w;
    logic          enable_w;
    logic          trip_d;

    always_comb begin
        enable_w = 1'b1;
        last_w   = LAST_S;
        unique case (wd_sel_e'(sel))
            WD_SEL_SHORT: last_w = LAST_S;
            WD_SEL_MID:   last_w = LAST_M;
            WD_SEL_LONG:  last_w = LAST_L;
            WD_SEL_OFF:   enable_w = 1'b0;
            default:      enable_w = 1'b0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        trip_d = 1'b0;
        if (!enable_w || hold || restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last_w) begin
            // Compare with >= so that a shorter limit still catches up.
            trip_d   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign trip_o = trip_d;

endmodule

// File: rtl/wdr_pulse.sv
`timescale 1ns/1ps
// Stretches a power-up or a trip into a reset pulse of fixed width.
module wdr_pulse #(
    parameter int PUR_CYCLES = 12,
    parameter int RST_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic busy_o
);
    localparam int PMAX = (PUR_CYCLES > RST_CYCLES) ? PUR_CYCLES : RST_CYCLES;
    localparam int PW   = $clog2(PMAX + 1);
    localparam logic [PW-1:0] PUR_LD = PW'(PUR_CYCLES - 1);
    localparam logic [PW-1:0] RST_LD = PW'(RST_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] left;
    } pls_s;

    pls_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.left == '0) st_d.busy = 1'b0;
            else                 st_d.left = st_q.left - 1'b1;
        end else if (trip) begin
            st_d.busy = 1'b1;
            st_d.left = RST_LD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b1, left: PUR_LD};
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/wdr_bus_watchdog.sv
`timescale 1ns/1ps
// Top: chip-select activity watchdog with open-drain reset output.
module wdr_bus_watchdog #(
    parameter int TMO_SHORT  = 25000,
    parameter int TMO_MID    = 100000,
    parameter int TMO_LONG   = 400000,
    parameter int PUR_CYCLES = 50000,
    parameter int RST_CYCLES = 50000,
    parameter bit ACT_LOW    = 1'b1
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       cs_n,
    input  logic [1:0] wd_sel,
    output logic       rst_oe,
    output logic       rst_lvl
);
    localparam logic ACT_LVL = ACT_LOW ? 1'b0 : 1'b1;

    logic cs_fall;
    logic tmo_trip;
    logic rst_busy;

    wdr_cs_sync #(
        .STAGES (2)
    ) u_sync (
        .clk    (clk),
        .rst_n  (por_n),
        .din    (cs_n),
        .fall_o (cs_fall)
    );

    wdr_timer #(
        .TMO_SHORT (TMO_SHORT),
        .TMO_MID   (TMO_MID),
        .TMO_LONG  (TMO_LONG)
    ) u_timer (
        .clk     (clk),
        .rst_n   (por_n),
        .sel     (wd_sel),
        .restart (cs_fall),
        .hold    (rst_busy),
        .trip_o  (tmo_trip)
    );

    wdr_pulse #(
        .PUR_CYCLES (PUR_CYCLES),
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (por_n),
        .trip   (tmo_trip),
        .busy_o (rst_busy)
    );

    assign rst_oe  = rst_busy;
    assign rst_lvl = ACT_LVL;

endmodule

// File: rtl/wdr_bus_watchdog_chk.sv
`timescale 1ns/1ps
module wdr_bus_watchdog_chk #(
    parameter int TMAX       = 40,
    parameter int PUR_CYCLES = 12,
    parameter int RST_CYCLES = 6
) (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] wd_sel,
    input logic       rst_oe,
    input logic       fall_w,
    input logic       trip_w
);
    logic [31:0] run_q;
    logic [31:0] quiet_q;
    logic [1:0]  sel_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q   <= '0;
            quiet_q <= '0;
            sel_q   <= 2'd3;
        end else begin
            sel_q <= wd_sel;
            if (rst_oe) run_q <= run_q + 1;
            else        run_q <= '0;
            if (rst_oe || fall_w || wd_sel == 2'd3 || wd_sel != sel_q)
                quiet_q <= '0;
            else if (quiet_q < 32'(TMAX + 2))
                quiet_q <= quiet_q + 1;
        end
    end

    // R1 and R3: every pulse has one of the two fixed widths.
    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_oe) |-> (run_q == 32'(RST_CYCLES) || run_q == 32'(PUR_CYCLES)));

    // R4: nothing trips while the select code is 3.
    p_off_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
        (wd_sel == 2'd3 && !rst_oe) |=> !rst_oe);

    // R2: a trip from the timer always opens a pulse.
    p_trip_pulse_r2: assert property (@(posedge clk) disable iff (!por_n)
        trip_w |=> rst_oe);

    // R2: no trip while a pulse is running.
    p_no_trip_busy_r2: assert property (@(posedge clk) disable iff (!por_n)
        rst_oe |-> !trip_w);

    // R5: a quiet stretch never outlasts the longest interval.
    p_idle_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
        quiet_q <= 32'(TMAX));

endmodule

bind wdr_bus_watchdog wdr_bus_watchdog_chk #(
    .TMAX       (wdr_pkg::max3(TMO_SHORT, TMO_MID, TMO_LONG)),
    .PUR_CYCLES (PUR_CYCLES),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk    (clk),
    .por_n  (por_n),
    .wd_sel (wd_sel),
    .rst_oe (rst_oe),
    .fall_w (cs_fall),
    .trip_w (tmo_trip)
);

// File: tb/test_wdr_bus_watchdog.sv
`timescale 1ns/1ps
module test_wdr_bus_watchdog;
    localparam int T_S = 10;
    localparam int T_M = 20;
    localparam int T_L = 40;
    localparam int PUR = 12;
    localparam int RST = 6;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] wd_sel = 2'd0;
    logic       rst_oe, rst_lvl;
    logic       hi_oe, hi_lvl;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    wdr_bus_watchdog #(
        .TMO_SHORT(T_S), .TMO_MID(T_M), .TMO_LONG(T_L),
        .PUR_CYCLES(PUR), .RST_CYCLES(RST), .ACT_LOW(1'b1)
    ) i_wdr_bus_watchdog (
        .clk(clk), .por_n(por_n), .cs_n(cs_n), .wd_sel(wd_sel),
        .rst_oe(rst_oe), .rst_lvl(rst_lvl)
    );

    wdr_bus_watchdog #(
        .TMO_SHORT(T_S), .TMO_MID(T_M), .TMO_LONG(T_L),
        .PUR_CYCLES(PUR), .RST_CYCLES(RST), .ACT_LOW(1'b0)
    ) i_wdr_bus_watchdog_hi (
        .clk(clk), .por_n(por_n), .cs_n(cs_n), .wd_sel(wd_sel),
        .rst_oe(hi_oe), .rst_lvl(hi_lvl)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Counts samples equal to val, starting with the current one.
    task automatic run_len(input logic val, output int n);
        n = 0;
        while (rst_oe === val && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts samples until rst_oe is seen high.
    task automatic wait_high(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_oe && n < 1000);
    endtask

    task automatic t_power_up;
        int n;
        repeat (3) @(negedge clk);
        check("R1", "oe during por", int'(rst_oe), 1);
        check("R8", "active-low level", int'(rst_lvl), 0);
        check("R8", "active-high level", int'(hi_lvl), 1);
        por_n = 1'b1;
        run_len(1'b1, n);
        check("R1", "power-up width", n, PUR);
    endtask

    task automatic t_steady_gaps;
        int n;
        run_len(1'b0, n);
        check("R2", "gap short", n, T_S);
        wd_sel = 2'd1;
        run_len(1'b1, n);
        check("R3", "pulse width", n, RST);
        run_len(1'b0, n);
        check("R2", "gap mid", n, T_M);
        wd_sel = 2'd2;
        run_len(1'b1, n);
        check("R3", "pulse width 2", n, RST);
        run_len(1'b0, n);
        check("R2", "gap long", n, T_L);
        wd_sel = 2'd0;
        run_len(1'b1, n);
        check("R8", "second polarity tracks", int'(hi_oe), int'(rst_oe));
    endtask

    task automatic t_fall_restart;
        int n;
        cs_n = 1'b0;
        wait_high(n);
        check("R5", "fall to trip latency", n, T_S + 3);
        run_len(1'b1, n);
        check("R3", "pulse after stuck low", n, RST);
        run_len(1'b0, n);
        check("R5", "stuck low gap", n, T_S);
        run_len(1'b1, n);
    endtask

    task automatic t_rise_ignored;
        int n;
        cs_n = 1'b1;
        run_len(1'b0, n);
        check("R6", "gap with rising edge", n, T_S);
        run_len(1'b1, n);
    endtask

    task automatic t_kicks;
        int n;
        int seen;
        seen = 0;
        wd_sel = 2'd1;
        for (int k = 0; k < 10; k++) begin
            cs_n = 1'b0;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (rst_oe) seen++;
            end
            cs_n = 1'b1;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (rst_oe) seen++;
            end
        end
        check("R7", "no reset while kicked", seen, 0);
        wait_high(n);
        check("R7", "trip after last kick", n, T_M + 3 - 8);
        run_len(1'b1, n);
    endtask

    task automatic t_off_and_shorten;
        int n;
        int seen;
        seen = 0;
        wd_sel = 2'd3;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (rst_oe) seen++;
        end
        check("R4", "no reset when off", seen, 0);
        wd_sel = 2'd2;
        repeat (30) @(negedge clk);
        check("R9", "no trip before shorten", int'(rst_oe), 0);
        wd_sel = 2'd0;
        wait_high(n);
        check("R9", "trip after shorten", n, 1);
        run_len(1'b1, n);
        check("R3", "pulse after shorten", n, RST);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_power_up();
        t_steady_gaps();
        t_fall_restart();
        t_rise_ignored();
        t_kicks();
        t_off_and_shorten();
        summary();
        $finish;
    end

endmodule